// File: doc/BRIEF.md
# Read completion checker with single retry

This block sits on the requester side of a local-bus-to-PCIe bridge and follows one outstanding non-posted request at a time. When a request is issued it records the address, length, tag and request kind, and it arms a completion timer. Posted writes are never tracked. Each incoming completion descriptor (header fields, three-bit completion status and an error flag) is compared against the tracked request. A good completion is passed through as a one-cycle strobe. A completion that does not match is dropped and flagged. An unsupported-request completion is dropped and flagged separately. An errored completion, or no completion before the timer runs out, starts one automatic reissue.

If the reissued request fails again, the block gives up. For reads it pulses a local read error, and in every case it goes back to idle. Four sticky interrupt status bits record the events. Each bit has its own enable, and the masked bits are ORed into a single interrupt line.

Top module: `cpl_retry_checker`

## Requirements
- R1: After reset the tracker is idle (`busy_o`=0), all strobes are low and `irq_status_o` is zero.
- R2: A request with `req_posted_i`=1 is not tracked: `busy_o` stays 0.
- R3: A completion is matched only when address, length and tag all equal the tracked values. Any other completion, including one received while idle, sets status bit 0 (unexpected) and leaves the pending request untouched.
- R4: A matched completion with status 3'b000 and the error flag clear gives `cpl_ok_o` high for exactly one cycle, on the edge that also clears `busy_o`.
- R5: A matched completion with status 3'b001 and the error flag clear sets status bit 1 and releases the tracker. It produces no `cpl_ok_o`, no reissue and no read error.
- R6: A matched completion with the error flag set, or with a status other than 3'b000 or 3'b001, is a failure and sets status bit 2. On the first failure of a request, `reissue_o` pulses for one cycle and the tracker stays busy.
- R7: With timeout limit L, a request that gets no matching completion times out: status bit 3 is set and `reissue_o` rises on the (L+1)th clock edge after the one that accepted the request. The timer reloads on every reissue.
- R8: A second consecutive failure ends the request with no reissue. It pulses `rd_err_o` for one cycle only when the kind is memory read (2'd0) or I/O read (2'd1). Kinds 2'd2 and 2'd3 end silently.
- R9: Every accepted request starts with its single retry available, whatever the previous request did.
- R10: Status bits are sticky and are cleared by writing 1 to the matching `irq_clear_i` bit. A set event in the same cycle wins over the clear.
- R11: `irq_o` is the OR of `irq_status_o & irq_enable_i`.
- R12: A new request offered while the tracker is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request issued this cycle |
| req_posted_i | input | 1 | Request is a posted write |
| req_kind_i | input | 2 | 0 mem read, 1 I/O read, 2/3 other non-posted |
| req_addr_i | input | ADDR_W | Request address |
| req_len_i | input | LEN_W | Request length |
| req_tag_i | input | TAG_W | Request tag |
| tmo_limit_i | input | TMO_W | Timeout limit in cycles |
| cpl_valid_i | input | 1 | Completion descriptor valid |
| cpl_addr_i | input | ADDR_W | Completion address |
| cpl_len_i | input | LEN_W | Completion length |
| cpl_tag_i | input | TAG_W | Completion tag |
| cpl_status_i | input | 3 | Completion status |
| cpl_err_i | input | 1 | Completion carries an error |
| irq_clear_i | input | 4 | Write-one-to-clear strobes |
| irq_enable_i | input | 4 | Per-bit interrupt enable |
| busy_o | output | 1 | Request outstanding |
| cpl_ok_o | output | 1 | Good completion strobe |
| reissue_o | output | 1 | Reissue the request |
| rd_err_o | output | 1 | Final read error strobe |
| irq_status_o | output | 4 | Sticky status: 0 unexpected, 1 unsupported, 2 completion error, 3 timeout |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is the path where the retry is used up. The stimulus has to produce two consecutive failures on one request, mix a bad completion with a timeout, and then show that the next request gets its retry back. The vector table runs error-then-error sequences for read and non-read kinds, and error-then-good and error-then-unsupported sequences. A directed test then lets a request time out twice with a short limit, checking the reissue edge and the read error edge cycle by cycle. Mismatches on each header field in turn are sent while a request is pending. A late completion sent after release shows that these are dropped without disturbing the tracker.

// File: rtl/cpl_chk_pkg.sv
package cpl_chk_pkg;
  localparam int IRQ_N     = 4;
  localparam int IRQ_UNEXP = 0;
  localparam int IRQ_UR    = 1;
  localparam int IRQ_CERR  = 2;
  localparam int IRQ_TMO   = 3;

  localparam logic [2:0] CST_SC = 3'b000;
  localparam logic [2:0] CST_UR = 3'b001;

  typedef enum logic [1:0] {
    CLS_GOOD = 2'd0,
    CLS_UR   = 2'd1,
    CLS_ERR  = 2'd2
  } cpl_cls_e;

  typedef enum logic {
    TRK_IDLE = 1'b0,
    TRK_WAIT = 1'b1
  } trk_state_e;
endpackage

// File: rtl/cpl_match.sv
module cpl_match
  import cpl_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10,
  parameter int TAG_W  = 8
) (
  input  logic [ADDR_W-1:0] trk_addr_i,
  input  logic [LEN_W-1:0]  trk_len_i,
  input  logic [TAG_W-1:0]  trk_tag_i,
  input  logic [ADDR_W-1:0] cpl_addr_i,
  input  logic [LEN_W-1:0]  cpl_len_i,
  input  logic [TAG_W-1:0]  cpl_tag_i,
  input  logic [2:0]        cpl_status_i,
  input  logic              cpl_err_i,
  output logic              hit_o,
  output cpl_cls_e          cls_o
);
  assign hit_o = (trk_addr_i == cpl_addr_i) &&
                 (trk_len_i  == cpl_len_i)  &&
                 (trk_tag_i  == cpl_tag_i);

  // error flag dominates the status field
  always_comb begin
    if (cpl_err_i)                  cls_o = CLS_ERR;
    else if (cpl_status_i == CST_SC) cls_o = CLS_GOOD;
    else if (cpl_status_i == CST_UR) cls_o = CLS_UR;
    else                             cls_o = CLS_ERR;
  end
endmodule

// File: rtl/cpl_timer.sv
module cpl_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [TMO_W-1:0] limit_i,
  output logic             zero_o
);
  logic [TMO_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= limit_i;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  a_r7_load_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == $past(limit_i));
  a_r7_count_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && run_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/cpl_irq_regs.sv
module cpl_irq_regs #(
  parameter int N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] status_o,
  output logic         irq_o
);
  logic [N-1:0] st_q;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        st_q[i] <= 1'b0;
      else if (set_i[i])  st_q[i] <= 1'b1;
      else if (clr_i[i])  st_q[i] <= 1'b0;
    end

    a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q[i] && !clr_i[i]) |=> st_q[i]);
    a_r10_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> st_q[i]);
  end

  assign status_o = st_q;
  assign irq_o    = |(st_q & en_i);
endmodule

// File: rtl/cpl_retry_checker.sv
module cpl_retry_checker
  import cpl_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 10,
  parameter int TAG_W  = 8,
  parameter int TMO_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_posted_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [TMO_W-1:0]  tmo_limit_i,
  input  logic              cpl_valid_i,
  input  logic [ADDR_W-1:0] cpl_addr_i,
  input  logic [LEN_W-1:0]  cpl_len_i,
  input  logic [TAG_W-1:0]  cpl_tag_i,
  input  logic [2:0]        cpl_status_i,
  input  logic              cpl_err_i,
  input  logic [3:0]        irq_clear_i,
  input  logic [3:0]        irq_enable_i,
  output logic              busy_o,
  output logic              cpl_ok_o,
  output logic              reissue_o,
  output logic              rd_err_o,
  output logic [3:0]        irq_status_o,
  output logic              irq_o
);
  trk_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic [TAG_W-1:0]  tag_q;
  logic [1:0]        kind_q;
  logic              retried_q;
  logic              ok_q, reissue_q, rd_err_q;

  logic     hit, tmr_zero;
  cpl_cls_e cls;

  cpl_match #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .TAG_W(TAG_W)) u_match (
    .trk_addr_i  (addr_q),
    .trk_len_i   (len_q),
    .trk_tag_i   (tag_q),
    .cpl_addr_i  (cpl_addr_i),
    .cpl_len_i   (cpl_len_i),
    .cpl_tag_i   (cpl_tag_i),
    .cpl_status_i(cpl_status_i),
    .cpl_err_i   (cpl_err_i),
    .hit_o       (hit),
    .cls_o       (cls)
  );

  logic waiting, accept, cpl_hit, unexp, tmo, cerr, fail, retry_now, give_up, is_read;

  assign waiting   = (state_q == TRK_WAIT);
  assign accept    = !waiting && req_valid_i && !req_posted_i;
  assign cpl_hit   = waiting && cpl_valid_i && hit;
  assign unexp     = cpl_valid_i && !cpl_hit;
  // a matching completion in the expiry cycle takes precedence
  assign tmo       = waiting && !cpl_hit && tmr_zero;
  assign cerr      = cpl_hit && (cls == CLS_ERR);
  assign fail      = cerr || tmo;
  assign retry_now = fail && !retried_q;
  assign give_up   = fail && retried_q;
  assign is_read   = (kind_q == 2'd0) || (kind_q == 2'd1);

  cpl_timer #(.TMO_W(TMO_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept || retry_now),
    .run_i  (waiting),
    .limit_i(tmo_limit_i),
    .zero_o (tmr_zero)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= TRK_IDLE;
      addr_q    <= '0;
      len_q     <= '0;
      tag_q     <= '0;
      kind_q    <= '0;
      retried_q <= 1'b0;
      ok_q      <= 1'b0;
      reissue_q <= 1'b0;
      rd_err_q  <= 1'b0;
    end else begin
      ok_q      <= 1'b0;
      reissue_q <= 1'b0;
      rd_err_q  <= 1'b0;
      if (accept) begin
        state_q   <= TRK_WAIT;
        addr_q    <= req_addr_i;
        len_q     <= req_len_i;
        tag_q     <= req_tag_i;
        kind_q    <= req_kind_i;
        retried_q <= 1'b0;
      end else if (cpl_hit && cls == CLS_GOOD) begin
        state_q   <= TRK_IDLE;
        retried_q <= 1'b0;
        ok_q      <= 1'b1;
      end else if (cpl_hit && cls == CLS_UR) begin
        state_q   <= TRK_IDLE;
        retried_q <= 1'b0;
      end else if (retry_now) begin
        retried_q <= 1'b1;
        reissue_q <= 1'b1;
      end else if (give_up) begin
        state_q   <= TRK_IDLE;
        retried_q <= 1'b0;
        rd_err_q  <= is_read;
      end
    end
  end

  logic [IRQ_N-1:0] irq_set;
  always_comb begin
    irq_set            = '0;
    irq_set[IRQ_UNEXP] = unexp;
    irq_set[IRQ_UR]    = cpl_hit && (cls == CLS_UR);
    irq_set[IRQ_CERR]  = cerr;
    irq_set[IRQ_TMO]   = tmo;
  end

  cpl_irq_regs #(.N(IRQ_N)) u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .set_i   (irq_set),
    .clr_i   (irq_clear_i),
    .en_i    (irq_enable_i),
    .status_o(irq_status_o),
    .irq_o   (irq_o)
  );

  assign busy_o    = waiting;
  assign cpl_ok_o  = ok_q;
  assign reissue_o = reissue_q;
  assign rd_err_o  = rd_err_q;

  a_r2_posted_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && req_posted_i) |=> !busy_o);
  a_r4_ok_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpl_ok_o |-> !busy_o);
  a_r6_reissue_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reissue_o |-> busy_o);
  a_r8_rd_err_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |-> !busy_o);
  a_r8_rd_err_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_err_o |=> !rd_err_o);
  a_r8_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cpl_ok_o, reissue_o, rd_err_o}));
  a_r12_busy_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !cpl_valid_i && !tmr_zero) |=> busy_o);
endmodule

// File: tb/cpl_retry_checker_tb.sv
module cpl_retry_checker_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid, req_posted;
  logic [1:0]  req_kind;
  logic [31:0] req_addr;
  logic [9:0]  req_len;
  logic [7:0]  req_tag;
  logic [15:0] tmo_limit;
  logic        cpl_valid;
  logic [31:0] cpl_addr;
  logic [9:0]  cpl_len;
  logic [7:0]  cpl_tag;
  logic [2:0]  cpl_status;
  logic        cpl_err;
  logic [3:0]  irq_clear, irq_enable;
  logic        busy, cpl_ok, reissue, rd_err, irq;
  logic [3:0]  irq_status;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpl_retry_checker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_posted_i(req_posted), .req_kind_i(req_kind),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_tag_i(req_tag),
    .tmo_limit_i(tmo_limit),
    .cpl_valid_i(cpl_valid), .cpl_addr_i(cpl_addr), .cpl_len_i(cpl_len),
    .cpl_tag_i(cpl_tag), .cpl_status_i(cpl_status), .cpl_err_i(cpl_err),
    .irq_clear_i(irq_clear), .irq_enable_i(irq_enable),
    .busy_o(busy), .cpl_ok_o(cpl_ok), .reissue_o(reissue), .rd_err_o(rd_err),
    .irq_status_o(irq_status), .irq_o(irq)
  );

  typedef struct packed {
    logic       rv;
    logic       posted;
    logic [1:0] kind;
    logic [7:0] addr;
    logic [3:0] len;
    logic [3:0] tag;
    logic       cv;
    logic [7:0] caddr;
    logic [3:0] clen;
    logic [3:0] ctag;
    logic [2:0] cst;
    logic       cerr;
    logic       e_busy;
    logic       e_ok;
    logic       e_re;
    logic       e_rde;
    logic [3:0] e_st;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    // R1 idle
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'b0000},
    // R2 posted write not tracked
    '{1'b1,1'b1,2'd2,8'h08,4'd1,4'd9, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'b0000},
    // mem read accepted
    '{1'b1,1'b0,2'd0,8'h10,4'd4,4'd1, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0000},
    // R3 tag mismatch
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h10,4'd4,4'd2,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0001},
    // R3 addr mismatch
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h11,4'd4,4'd1,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0001},
    // R3 length mismatch
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h10,4'd5,4'd1,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0001},
    // R12 request while busy ignored
    '{1'b1,1'b0,2'd1,8'h20,4'd2,4'd3, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0001},
    // R4 good completion for original request
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h10,4'd4,4'd1,3'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'b0001},
    // io read
    '{1'b1,1'b0,2'd1,8'h30,4'd1,4'd5, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0001},
    // R6 error flag -> reissue
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h30,4'd1,4'd5,3'd0,1'b1, 1'b1,1'b0,1'b1,1'b0,4'b0101},
    // R8 abort status second failure -> read error
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h30,4'd1,4'd5,3'd4,1'b0, 1'b0,1'b0,1'b0,1'b1,4'b0101},
    // non-read kind
    '{1'b1,1'b0,2'd2,8'h40,4'd2,4'd6, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0101},
    // R6 first failure
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h40,4'd2,4'd6,3'd0,1'b1, 1'b1,1'b0,1'b1,1'b0,4'b0101},
    // R8 second failure on non-read: silent
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h40,4'd2,4'd6,3'd0,1'b1, 1'b0,1'b0,1'b0,1'b0,4'b0101},
    // mem read
    '{1'b1,1'b0,2'd0,8'h50,4'd3,4'd7, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0101},
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h50,4'd3,4'd7,3'd0,1'b1, 1'b1,1'b0,1'b1,1'b0,4'b0101},
    // R4 good after retry
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h50,4'd3,4'd7,3'd0,1'b0, 1'b0,1'b1,1'b0,1'b0,4'b0101},
    // R9 fresh request gets its retry
    '{1'b1,1'b0,2'd0,8'h60,4'd3,4'd8, 1'b0,8'h00,4'd0,4'd0,3'd0,1'b0, 1'b1,1'b0,1'b0,1'b0,4'b0101},
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h60,4'd3,4'd8,3'd2,1'b0, 1'b1,1'b0,1'b1,1'b0,4'b0101},
    // R5 unsupported request releases, no strobe
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h60,4'd3,4'd8,3'd1,1'b0, 1'b0,1'b0,1'b0,1'b0,4'b0111},
    // R3 late completion while idle is unexpected
    '{1'b0,1'b0,2'd0,8'h00,4'd0,4'd0, 1'b1,8'h60,4'd3,4'd8,3'd0,1'b0, 1'b0,1'b0,1'b0,1'b0,4'b0111}
  };

  task automatic idle_inputs();
    req_valid = 0; req_posted = 0; req_kind = 0; req_addr = 0; req_len = 0; req_tag = 0;
    cpl_valid = 0; cpl_addr = 0; cpl_len = 0; cpl_tag = 0; cpl_status = 0; cpl_err = 0;
    irq_clear = 0;
  endtask

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] outs();
    return {busy, cpl_ok, reissue, rd_err, irq_status};
  endfunction

  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    tmo_limit  = 16'd40;
    irq_enable = 4'h0;
    #(CLK_PERIOD*2);
    // R1 reset state
    check("R1", {outs(), irq}, {8'h00});
    check("R1 irq", {7'd0, irq}, 8'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idle_inputs();
      req_valid  = TBL[i].rv;   req_posted = TBL[i].posted; req_kind = TBL[i].kind;
      req_addr   = 32'(TBL[i].addr); req_len = 10'(TBL[i].len); req_tag = 8'(TBL[i].tag);
      cpl_valid  = TBL[i].cv;   cpl_addr = 32'(TBL[i].caddr);
      cpl_len    = 10'(TBL[i].clen); cpl_tag = 8'(TBL[i].ctag);
      cpl_status = TBL[i].cst;  cpl_err = TBL[i].cerr;
      step();
      check($sformatf("vector %0d", i), outs(),
            {TBL[i].e_busy, TBL[i].e_ok, TBL[i].e_re, TBL[i].e_rde, TBL[i].e_st});
    end

    // R11 masking
    @(negedge clk); idle_inputs(); irq_enable = 4'b0010; #1;
    check("R11 enabled bit", {7'd0, irq}, 8'd1);
    irq_enable = 4'b1000; #1;
    check("R11 masked bits", {7'd0, irq}, 8'd0);

    // R10 set wins over clear, then clear
    @(negedge clk); cpl_valid = 1; cpl_addr = 32'h77; irq_clear = 4'b0001;
    step();
    check("R10 set wins", {4'd0, irq_status}, 8'h07);
    @(negedge clk); idle_inputs(); irq_clear = 4'b0111;
    step();
    check("R10 w1c", {4'd0, irq_status}, 8'h00);

    // R7 timeout with L=5, then second timeout gives R8 read error
    @(negedge clk); idle_inputs(); tmo_limit = 16'd5; irq_enable = 4'b1000;
    req_valid = 1; req_kind = 2'd0; req_addr = 32'h90; req_len = 10'd2; req_tag = 8'd11;
    step();
    @(negedge clk); idle_inputs();
    for (int k = 1; k <= 12; k++) begin
      if (k > 1) @(negedge clk);
      step();
      if (k == 6) begin
        check("R7 reissue at L+1", {busy, reissue, rd_err, irq_status[3]}, {4'b1101});
        check("R11 irq on timeout", {7'd0, irq}, 8'd1);
      end else if (k == 12)
        check("R8 second timeout rd_err", {busy, reissue, rd_err, 1'b0}, {4'b0010});
      else
        check($sformatf("R7 wait cycle %0d", k), {6'd0, reissue, rd_err}, 8'd0);
    end
    step();
    check("R8 rd_err one cycle", {7'd0, rd_err}, 8'd0);

    // R12 / R9 new request after give-up gets a retry
    @(negedge clk); irq_clear = 4'hF; tmo_limit = 16'd40;
    req_valid = 1; req_kind = 2'd1; req_addr = 32'hA0; req_len = 10'd1; req_tag = 8'd12;
    step();
    @(negedge clk); idle_inputs();
    cpl_valid = 1; cpl_addr = 32'hA0; cpl_len = 10'd1; cpl_tag = 8'd12; cpl_err = 1;
    step();
    check("R9 retry after give-up", {6'd0, busy, reissue}, 8'd3);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule